// File: doc/BRIEF.md
# Parallel Flash Sector Write Controller

This block sits on the host side of a byte-wide parallel flash that is rewritten one 256-byte sector at a time. A single-cycle start request names the sector. The block then takes the sector's contents as a stream of bytes over a valid/ready handshake. For each byte it produces one write strobe cycle on the flash pins: chip enable low, output enable high, and a one-cycle write-enable low pulse. The address and data are held steady around that pulse.

Once the device has latched a byte, it begins programming on its own if the next write pulse comes too late. The controller therefore watches how long it waits for each new byte after the first. If the stream stalls up to the limit, the controller abandons the load and reports an underrun rather than let a partial sector be programmed. After the final byte it polls the device with read cycles spaced by a set interval. It compares the top data bit with the top bit of the last byte written, and finishes with a done pulse on a match or a timeout pulse if the match never comes.

Top module: `sector_prog`

## Requirements
- R1: After reset, and whenever no sequence is running, all three strobes are high (inactive), the data drive enable is 0, and `in_ready`, `busy`, `done`, `err_underrun` and `err_timeout` are 0.
- R2: A write-enable low cycle only occurs with chip enable low, output enable high and data driven. The address and data present in the cycle before the pulse stay unchanged through the pulse and the cycle after it.
- R3: Bytes are written at ascending byte offsets 0 to 255. The flash address is the sector number in the upper bits concatenated with the 8-bit offset, and each sequence makes exactly 256 write pulses.
- R4: A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the controller waits for the next byte, and the n-th accepted byte is the data written at offset n.
- R5: Once at least one byte has been written, the controller may spend GAP_LIMIT cycles waiting for a byte. If the last of them passes without `in_valid`, it pulses `err_underrun` for one cycle and returns to idle, and no further write pulse is made.
- R6: There is no wait limit before the first byte of a sequence.
- R7: From a write-enable rising edge to the next falling edge, write enable is high for at most GAP_LIMIT+2 cycles.
- R8: Polling reads hold chip enable and output enable low with write enable high and data not driven, at the address of offset 255. Between reads the strobes rest high for at least POLL_GAP cycles.
- R9: When a polling read returns a top data bit equal to the top bit of the byte written at offset 255, `done` pulses for exactly one cycle and the controller returns to idle. At most one of `done`, `err_underrun`, `err_timeout` is high in any cycle.
- R10: If no read matches within TIMEOUT_CYC cycles after the last write pulse ends, `err_timeout` pulses for one cycle (TIMEOUT_CYC+1 cycles after the last rising edge of write enable) and `done` is not raised.
- R11: A start request while `busy` is high is ignored: the sector in the flash address does not change until the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sector write (taken when idle) |
| sector | input | SECTOR_W | Sector number, captured on start |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | DATA_W | Stream byte |
| in_ready | output | 1 | Controller accepts a byte this cycle |
| flash_addr | output | SECTOR_W+8 | Flash address {sector, offset} |
| flash_dout | output | DATA_W | Write data to flash |
| flash_drv | output | 1 | Data bus drive enable |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_poll_bit | input | 1 | Top data bit read back from flash |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on programming complete |
| err_underrun | output | 1 | One-cycle pulse when the byte stream stalled too long |
| err_timeout | output | 1 | One-cycle pulse when polling never matched |

## Verification
The bench stalls the stream by exactly the longest allowed wait on every byte after the first, and by one cycle more in a separate run. A wait counter that is off by one would either raise a false underrun or let one late byte through and write it. It delays the very first byte far past the limit; a design that timed that wait would abort a healthy sequence. The bench uses both polarities of the final byte's top bit and a device that stays busy for a long time. A design that compared the wrong bit or polarity would finish early or never, and a timeout counter started at the wrong point would fire in the wrong cycle. A start pulse in the middle of a load must not change the sector in the address.

// File: rtl/sector_prog_pkg.sv
package sector_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_PGAP,
    ST_RDA,
    ST_RDB
  } sp_state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drv;
  } sp_strobe_t;

  localparam sp_strobe_t STROBE_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};

endpackage

// File: rtl/sp_rst_sync.sv
module sp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sp_counter.sv
module sp_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr)     q_d = '0;
    else if (en) q_d = q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/sp_strobe_gen.sv
module sp_strobe_gen
  import sector_prog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sp_state_e  state_d,
  output sp_strobe_t strobe_q
);
  sp_strobe_t strobe_d;

  always_comb begin
    strobe_d = STROBE_IDLE;
    case (state_d)
      ST_SETUP: begin strobe_d.ce_n = 1'b0; strobe_d.drv = 1'b1; end
      ST_PULSE: begin strobe_d.ce_n = 1'b0; strobe_d.drv = 1'b1; strobe_d.we_n = 1'b0; end
      ST_HOLD:  begin strobe_d.ce_n = 1'b0; strobe_d.drv = 1'b1; end
      ST_RDA,
      ST_RDB:   begin strobe_d.ce_n = 1'b0; strobe_d.oe_n = 1'b0; end
      default:  strobe_d = STROBE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= STROBE_IDLE;
    else        strobe_q <= strobe_d;
  end
endmodule

// File: rtl/sector_prog.sv
module sector_prog
  import sector_prog_pkg::*;
#(
  parameter int SECTOR_W    = 10,
  parameter int DATA_W      = 8,
  parameter int GAP_LIMIT   = 16384,
  parameter int POLL_GAP    = 8,
  parameter int TIMEOUT_CYC = 1250000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [SECTOR_W-1:0]   sector,
  input  logic                  in_valid,
  input  logic [DATA_W-1:0]     in_data,
  output logic                  in_ready,
  output logic [SECTOR_W+7:0]   flash_addr,
  output logic [DATA_W-1:0]     flash_dout,
  output logic                  flash_drv,
  output logic                  flash_ce_n,
  output logic                  flash_oe_n,
  output logic                  flash_we_n,
  input  logic                  flash_poll_bit,
  output logic                  busy,
  output logic                  done,
  output logic                  err_underrun,
  output logic                  err_timeout
);
  localparam int OFS_W  = 8;
  localparam logic [OFS_W-1:0] LAST_OFS = '1;
  localparam int GAP_W  = $clog2(GAP_LIMIT + 1);
  localparam int POLL_W = $clog2(POLL_GAP + 1);
  localparam int TMO_W  = $clog2(TIMEOUT_CYC + 1);

  logic rst_sync_n;
  sp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  sp_state_e state_q, state_d;
  logic [SECTOR_W-1:0] sector_q;
  logic [OFS_W-1:0]    ofs_q;
  logic [DATA_W-1:0]   data_q;
  logic [GAP_W-1:0]    gap_cnt;
  logic [POLL_W-1:0]   poll_cnt;
  logic [TMO_W-1:0]    tmo_cnt;

  logic load_sector, take_byte, ofs_clr, ofs_inc;
  logic gap_clr, gap_en, poll_clr, poll_en, tmo_clr, tmo_en;
  logic done_d, und_d, tmo_d, polling;

  sp_counter #(.W(GAP_W))  u_gap  (.clk(clk), .rst_n(rst_sync_n), .clr(gap_clr),  .en(gap_en),  .q(gap_cnt));
  sp_counter #(.W(POLL_W)) u_poll (.clk(clk), .rst_n(rst_sync_n), .clr(poll_clr), .en(poll_en), .q(poll_cnt));
  sp_counter #(.W(TMO_W))  u_tmo  (.clk(clk), .rst_n(rst_sync_n), .clr(tmo_clr),  .en(tmo_en),  .q(tmo_cnt));

  assign polling = (state_q == ST_PGAP) || (state_q == ST_RDA) || (state_q == ST_RDB);

  // next-state logic
  always_comb begin
    state_d     = state_q;
    load_sector = 1'b0;
    take_byte   = 1'b0;
    ofs_clr     = 1'b0;
    ofs_inc     = 1'b0;
    gap_clr     = 1'b0;
    gap_en      = 1'b0;
    poll_clr    = 1'b0;
    poll_en     = 1'b0;
    tmo_clr     = 1'b0;
    tmo_en      = 1'b0;
    done_d      = 1'b0;
    und_d       = 1'b0;
    tmo_d       = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        load_sector = 1'b1;
        ofs_clr     = 1'b1;
        gap_clr     = 1'b1;
        state_d     = ST_WAIT;
      end
      ST_WAIT: begin
        if (in_valid) begin
          take_byte = 1'b1;
          state_d   = ST_SETUP;
        end else if (ofs_q != '0) begin
          if (gap_cnt == GAP_W'(GAP_LIMIT - 1)) begin
            und_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            gap_en = 1'b1;
          end
        end
      end
      ST_SETUP: state_d = ST_PULSE;
      ST_PULSE: state_d = ST_HOLD;
      ST_HOLD: begin
        if (ofs_q == LAST_OFS) begin
          poll_clr = 1'b1;
          tmo_clr  = 1'b1;
          state_d  = ST_PGAP;
        end else begin
          ofs_inc = 1'b1;
          gap_clr = 1'b1;
          state_d = ST_WAIT;
        end
      end
      ST_PGAP: begin
        tmo_en = 1'b1;
        if (poll_cnt == POLL_W'(POLL_GAP - 1)) begin
          poll_clr = 1'b1;
          state_d  = ST_RDA;
        end else begin
          poll_en = 1'b1;
        end
      end
      ST_RDA: begin
        tmo_en  = 1'b1;
        state_d = ST_RDB;
      end
      ST_RDB: begin
        tmo_en = 1'b1;
        if (flash_poll_bit == data_q[DATA_W-1]) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_PGAP;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (polling && !done_d && (tmo_cnt == TMO_W'(TIMEOUT_CYC - 1))) begin
      tmo_d   = 1'b1;
      state_d = ST_IDLE;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q      <= ST_IDLE;
      sector_q     <= '0;
      ofs_q        <= '0;
      data_q       <= '0;
      done         <= 1'b0;
      err_underrun <= 1'b0;
      err_timeout  <= 1'b0;
    end else begin
      state_q      <= state_d;
      done         <= done_d;
      err_underrun <= und_d;
      err_timeout  <= tmo_d;
      if (load_sector) sector_q <= sector;
      if (ofs_clr)      ofs_q <= '0;
      else if (ofs_inc) ofs_q <= ofs_q + OFS_W'(1);
      if (take_byte) data_q <= in_data;
    end
  end

  sp_strobe_t strobe_q;
  sp_strobe_gen u_strobe (.clk(clk), .rst_n(rst_sync_n), .state_d(state_d), .strobe_q(strobe_q));

  assign flash_ce_n = strobe_q.ce_n;
  assign flash_oe_n = strobe_q.oe_n;
  assign flash_we_n = strobe_q.we_n;
  assign flash_drv  = strobe_q.drv;
  assign flash_addr = {sector_q, ofs_q};
  assign flash_dout = data_q;
  assign in_ready   = (state_q == ST_WAIT);
  assign busy       = (state_q != ST_IDLE);

  AST_WE_WITH_CE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !flash_we_n |-> (!flash_ce_n && flash_oe_n && flash_drv)); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !flash_we_n |-> ($stable(flash_addr) && $stable(flash_dout))); // R2
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(flash_we_n) |-> ($stable(flash_dout) && $stable(flash_addr) && !flash_ce_n)); // R2
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !flash_oe_n |-> (flash_we_n && !flash_drv)); // R8
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    gap_cnt < GAP_W'(GAP_LIMIT)); // R5
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({done, err_underrun, err_timeout})); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done); // R9
  AST_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done || err_underrun || err_timeout) |-> (!busy && flash_we_n && flash_oe_n)); // R1
  AST_SECTOR_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && $past(busy)) |-> $stable(sector_q)); // R11
endmodule

// File: tb/sector_prog_tb.sv
module sector_prog_tb;
  localparam int SW  = 10;
  localparam int GAP = 12;
  localparam int PG  = 5;
  localparam int TMO = 700;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, start, in_valid;
  logic [SW-1:0] sector;
  logic [7:0]    in_data;
  logic          in_ready, flash_drv, flash_ce_n, flash_oe_n, flash_we_n, flash_poll_bit;
  logic [SW+7:0] flash_addr;
  logic [7:0]    flash_dout;
  logic          busy, done, err_underrun, err_timeout;

  sector_prog #(.SECTOR_W(SW), .DATA_W(8), .GAP_LIMIT(GAP), .POLL_GAP(PG), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sector(sector), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .flash_addr(flash_addr), .flash_dout(flash_dout), .flash_drv(flash_drv),
    .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
    .flash_poll_bit(flash_poll_bit), .busy(busy), .done(done), .err_underrun(err_underrun),
    .err_timeout(err_timeout));

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference device model and protocol monitor
  logic [SW-1:0] exp_sector;
  int            busy_len;
  logic [7:0]    mem [256];
  logic [7:0]    last_byte;
  logic [SW+7:0] fall_addr;
  logic [7:0]    fall_data;
  int  cyc = 0, writes = 0, high_cnt = 0, busy_left = 0, busy_end = 0, last_rise = 0;
  int  idle_cnt = 0, done_cnt = 0, und_cnt = 0, tmo_cnt = 0, done_cyc = 0, tmo_cyc = 0;
  bit  prev_we = 1'b1, prev_rd = 1'b0, rd_seen = 1'b0, prev_busy = 1'b0, prev_done = 1'b0;

  assign flash_poll_bit = (!flash_ce_n && !flash_oe_n) ?
                          ((busy_left > 0) ? ~last_byte[7] : last_byte[7]) : 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (busy && !prev_busy) begin
        writes = 0; rd_seen = 1'b0; busy_left = 0; high_cnt = 0; prev_we = 1'b1;
      end
      if (busy_left > 0) begin
        busy_left--;
        if (busy_left == 0) busy_end = cyc;
      end
      if (prev_we && !flash_we_n) begin
        chk(!flash_ce_n && flash_oe_n && flash_drv, "R2", "strobes at WE fall", {flash_ce_n, flash_oe_n, flash_drv}, 3'b011);
        if (writes > 0) chk(high_cnt <= GAP + 2, "R7", "WE high gap", high_cnt, GAP + 2);
        fall_addr = flash_addr;
        fall_data = flash_dout;
      end else if (!prev_we && flash_we_n) begin
        chk(flash_addr == fall_addr && flash_dout == fall_data, "R2", "addr/data across pulse",
            {flash_addr, flash_dout}, {fall_addr, fall_data});
        chk(writes < 256 && flash_addr == {exp_sector, 8'(writes)}, "R3", "write address",
            flash_addr, {exp_sector, 8'(writes)});
        if (writes < 256) mem[writes] = flash_dout;
        writes++;
        high_cnt = 1;
        last_rise = cyc;
        if (writes == 256) begin
          last_byte = flash_dout;
          busy_left = busy_len;
        end
      end else if (flash_we_n) begin
        high_cnt++;
      end
      prev_we = flash_we_n;
      if (!flash_ce_n && !flash_oe_n) begin
        if (!prev_rd) begin
          chk(flash_we_n && !flash_drv && flash_addr == {exp_sector, 8'hFF}, "R8", "poll read cycle",
              {flash_we_n, flash_drv, flash_addr}, {2'b10, exp_sector, 8'hFF});
          if (rd_seen) chk(idle_cnt >= PG, "R8", "poll spacing", idle_cnt, PG);
          rd_seen = 1'b1;
        end
        idle_cnt = 0;
        prev_rd = 1'b1;
      end else begin
        idle_cnt++;
        prev_rd = 1'b0;
      end
      if (done) begin
        done_cnt++; done_cyc = cyc;
        chk(!prev_done, "R9", "done width", 2, 1);
      end
      if (err_underrun) und_cnt++;
      if (err_timeout) begin tmo_cnt++; tmo_cyc = cyc; end
      prev_done = done;
      prev_busy = busy;
    end
  end

  task automatic begin_seq(input logic [SW-1:0] sec, input int blen);
    exp_sector = sec; busy_len = blen; sector = sec; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    in_valid = 1'b1; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_end(input int maxc);
    int base;
    base = done_cnt + und_cnt + tmo_cnt;
    for (int i = 0; i < maxc; i++) begin
      if (done_cnt + und_cnt + tmo_cnt != base) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic check_mem(input string tag, input int kind);
    int bad;
    bad = 0;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] e;
      e = (kind == 0) ? (8'(i) ^ 8'h5A) : ~8'(i);
      if (mem[i] !== e) bad++;
    end
    chk(bad == 0, tag, "sector contents mismatches", bad, 0);
  endtask

  task automatic check_idle(input string tag);
    chk(!busy && !in_ready && flash_ce_n && flash_oe_n && flash_we_n && !flash_drv &&
        !done && !err_underrun && !err_timeout, tag, "idle outputs",
        {busy, in_ready, flash_ce_n, flash_oe_n, flash_we_n, flash_drv, done, err_underrun, err_timeout},
        9'b001110000);
  endtask

  initial begin
    int d0, u0, t0;
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_data = '0; sector = '0;
    exp_sector = '0; busy_len = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1");

    // sequence A: steady stream, last byte top bit 1
    d0 = done_cnt; u0 = und_cnt; t0 = tmo_cnt;
    begin_seq(10'd3, 40);
    for (int i = 0; i < 256; i++) push(8'(i) ^ 8'h5A);
    wait_end(3000);
    chk(done_cnt == d0 + 1 && und_cnt == u0 && tmo_cnt == t0, "R9", "sequence A result",
        done_cnt - d0, 1);
    chk(writes == 256, "R3", "write count A", writes, 256);
    check_mem("R4", 0);
    chk(done_cyc > busy_end && done_cyc - busy_end <= PG + 6, "R9", "done after device ready",
        done_cyc - busy_end, PG + 6);
    check_idle("R1");

    // sequence B: late first byte, every later byte at the wait limit, start while busy
    d0 = done_cnt; u0 = und_cnt;
    begin_seq(10'h2A5, 100);
    repeat (5 * GAP) @(negedge clk);
    push(8'hFF);  // R6: first byte far beyond the limit
    for (int i = 1; i < 256; i++) begin
      if (i == 100) begin
        sector = 10'd1; start = 1'b1;  // R11
        @(negedge clk);
        start = 1'b0; sector = 10'h2A5;
        repeat (GAP + 1) @(negedge clk);
      end else begin
        repeat (GAP + 2) @(negedge clk);  // R7 boundary
      end
      push(~8'(i));
    end
    wait_end(3000);
    chk(und_cnt == u0, "R6", "no underrun with late first byte and boundary stalls", und_cnt - u0, 0);
    chk(done_cnt == d0 + 1, "R9", "sequence B done (top bit 0)", done_cnt - d0, 1);
    chk(writes == 256, "R11", "write count with stray start", writes, 256);
    check_mem("R4", 1);

    // sequence C: stall one cycle past the limit
    u0 = und_cnt; d0 = done_cnt;
    begin_seq(10'd5, 10);
    for (int i = 0; i < 10; i++) push(8'(i) ^ 8'h5A);
    repeat (GAP + 3) @(negedge clk);
    in_valid = 1'b1; in_data = 8'h77;
    repeat (6) @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(und_cnt == u0 + 1, "R5", "underrun pulse", und_cnt - u0, 1);
    chk(writes == 10, "R5", "no write after underrun", writes, 10);
    chk(done_cnt == d0, "R5", "no done after underrun", done_cnt - d0, 0);
    check_idle("R1");

    // sequence D: device never finishes
    d0 = done_cnt; t0 = tmo_cnt;
    begin_seq(10'd7, 1000000);
    for (int i = 0; i < 256; i++) push(8'(i) ^ 8'h5A);
    wait_end(TMO + 200);
    chk(tmo_cnt == t0 + 1 && done_cnt == d0, "R10", "timeout result", tmo_cnt - t0, 1);
    chk(tmo_cyc - last_rise == TMO + 1, "R10", "timeout cycle", tmo_cyc - last_rise, TMO + 1);
    check_idle("R1");

    // sequence E: highest sector, device ready at once
    d0 = done_cnt;
    begin_seq(10'h3FF, 1);
    for (int i = 0; i < 256; i++) push(8'(i) ^ 8'h5A);
    wait_end(3000);
    chk(done_cnt == d0 + 1, "R9", "sequence E done", done_cnt - d0, 1);
    chk(writes == 256, "R3", "write count E", writes, 256);
    check_mem("R4", 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule